// File: doc/BRIEF.md
# Paired 8-bit Timer with Shared Output Flip-Flop

This block holds two 8-bit up-counters. Each counter has its own compare value. The two counters share one prescaler and one output flip-flop. A two-bit mode selects how they work together. They can run as two separate interval timers, as one 16-bit interval timer, as a programmable pulse generator that toggles the output on two compare points, or as an 8-bit pulse-width modulator with a period of 2^n.

Software controls the block through a small write-only register port: run bits, mode and clock selects, a flip-flop command field, and the two compare values. Each channel raises a one-cycle interrupt pulse on its event. The first compare register can be double-buffered. A buffered value is then copied in only at the end of a pulse period, so a pulse width can be changed without glitches while the timer runs. By usage rule, compare registers are rewritten directly only while the timer is stopped.

Top module: `tmr_pair8`

## Requirements
- R1: After reset, `tmr_out`, `irq0` and `irq1` are low and every control field is zero: both channels stopped, dual 8-bit mode, double buffer off, automatic inversion off.
- R2: With address 1 bits [1:0] = 00 (dual 8-bit mode) and channel 0 clocked every cycle (address 1 bits [3:2] = 00), counter 0 advances on each tick. A tick that finds it equal to the compare value at address 3 clears it and raises `irq0` for one cycle on the next cycle. The interrupt period is compare+1 cycles.
- R3: In dual 8-bit mode, channel 1 clock select 00 (address 1 bits [5:4]) makes counter 1 count channel-0 matches. `irq1` then repeats every (cmp0+1)*(cmp1+1) ticks of channel 0. The compare value for channel 1 is at address 4.
- R4: Clock-select values 1, 2 and 3 tick a channel once every 4, 32 and 512 clock cycles from a free-running 9-bit prescaler.
- R5: Mode 01 cascades the counters into one 16-bit counter compared against {address 4, address 3}. It clears on a match and pulses only `irq1`, with period {cmp1,cmp0}+1 ticks. `irq0` stays low.
- R6: The run bits are address 0 bit 0 (channel 0, and the whole counter in modes 01, 10, 11) and bit 1 (channel 1). A run bit at 0 holds its counter at zero and gives no interrupt. After it is set, the first match comes exactly cmp+1 ticks later.
- R7: Writing address 2 applies command bits [1:0] to `tmr_out` on the next cycle: 00 inverts, 01 sets, 10 clears, 11 leaves it unchanged. A command takes priority over a hardware event in the same cycle.
- R8: In modes 00 and 01, address 2 bit 2 enables automatic inversion of `tmr_out` on each match. Bit 3 picks the source in mode 00: 0 for channel 0, 1 for channel 1.
- R9: Mode 10 (pulse generation): `tmr_out` inverts when counter 0 matches cmp0 (with `irq0`) and again when it matches cmp1 (with `irq1`), where it also clears. Starting from low, the output is low for cmp0+1 ticks and high for cmp1-cmp0 ticks, given cmp0 < cmp1.
- R10: Mode 11 (PWM): address 1 bits [7:6] set the period 2^n, with 00 giving n=6, 01 giving n=7 and otherwise n=8. Counter overflow clears `tmr_out` and pulses `irq1`. A match with cmp0 sets it and pulses `irq0`. The high time is 2^n-cmp0-1 ticks; overflow wins a tie.
- R11: With address 0 bit 2 set, a write to address 3 goes into a buffer. The buffer is copied to cmp0 on overflow in mode 11 and on the cmp1 match in mode 10, and never in modes 00 and 01. With the bit clear, the write takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 run, 1 mode, 2 flip-flop control, 3 cmp0, 4 cmp1) |
| wr_data | input | CW | Register write data |
| tmr_out | output | 1 | Shared timer output flip-flop |
| irq0 | output | 1 | Channel 0 event pulse |
| irq1 | output | 1 | Channel 1 event pulse |

## Verification
The bench measures periods and high times and compares them with closed-form formulas for each mode. An off-by-one in the compare-and-clear step would shift every period by one tick. A cascade wired to the wrong carry would give the product of the compare values instead of the product of compare values plus one. A double buffer that loads at the wrong point would change the width in dual 8-bit mode, or fail to change it in pulse-generation and PWM modes. The bench checks restart latency after a stop, which catches a counter that keeps its value instead of holding at zero. It also walks the four flip-flop commands with no hardware events present, so an inverted command encoding shows up directly.

// File: rtl/tp8_pkg.sv
package tp8_pkg;
   typedef enum logic [1:0] {
      MD_DUAL8 = 2'b00,
      MD_CAS16 = 2'b01,
      MD_PPG   = 2'b10,
      MD_PWM   = 2'b11
   } tp8_mode_e;

   typedef enum logic [1:0] {
      FF_INV  = 2'b00,
      FF_SET  = 2'b01,
      FF_CLR  = 2'b10,
      FF_HOLD = 2'b11
   } tp8_ffcmd_e;

   localparam logic [2:0] A_RUN  = 3'd0;
   localparam logic [2:0] A_MODE = 3'd1;
   localparam logic [2:0] A_FFC  = 3'd2;
   localparam logic [2:0] A_CMP0 = 3'd3;
   localparam logic [2:0] A_CMP1 = 3'd4;

   typedef struct packed {
      logic      run0;
      logic      run1;
      logic      dbuf_en;
      tp8_mode_e mode;
      logic [1:0] ck0;
      logic [1:0] ck1;
      logic [1:0] plen;
      logic      auto_en;
      logic      auto_src;
   } tp8_ctl_t;
endpackage

// File: rtl/tp8_presc.sv
module tp8_presc #(
   parameter int PRE_W = 9,
   parameter int TAP1  = 2,
   parameter int TAP2  = 5,
   parameter int TAP3  = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   output logic [3:0] tick
);
   localparam int TAPS [3] = '{TAP1, TAP2, TAP3};

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_q <= '0;
      else if (!run) pre_q <= '0;
      else           pre_q <= pre_q + 1'b1;
   end

   assign tick[0] = 1'b1;
   for (genvar g = 1; g < 4; g++) begin : g_tap
      assign tick[g] = run & (&pre_q[TAPS[g-1]-1:0]);
   end
endmodule

// File: rtl/tp8_regs.sv
module tp8_regs
   import tp8_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [CW-1:0] wr_data,
   input  logic          load,
   output tp8_ctl_t      ctl,
   output logic [CW-1:0] cmp0,
   output logic [CW-1:0] cmp1,
   output logic          ff_we,
   output tp8_ffcmd_e    ff_cmd
);
   logic [CW-1:0] buf_q;

   assign ff_we  = wr_en && (wr_addr == A_FFC);
   assign ff_cmd = tp8_ffcmd_e'(wr_data[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl   <= '0;
         cmp0  <= '0;
         cmp1  <= '0;
         buf_q <= '0;
      end else begin
         if (load) cmp0 <= buf_q;
         if (wr_en) begin
            case (wr_addr)
               A_RUN: begin
                  ctl.run0    <= wr_data[0];
                  ctl.run1    <= wr_data[1];
                  ctl.dbuf_en <= wr_data[2];
               end
               A_MODE: begin
                  ctl.mode <= tp8_mode_e'(wr_data[1:0]);
                  ctl.ck0  <= wr_data[3:2];
                  ctl.ck1  <= wr_data[5:4];
                  ctl.plen <= wr_data[7:6];
               end
               A_FFC: begin
                  ctl.auto_en  <= wr_data[2];
                  ctl.auto_src <= wr_data[3];
               end
               A_CMP0: begin
                  buf_q <= wr_data;
                  if (!ctl.dbuf_en) cmp0 <= wr_data;
               end
               A_CMP1: cmp1 <= wr_data;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/tp8_core.sv
module tp8_core
   import tp8_pkg::*;
#(
   parameter int CW     = 8,
   parameter int PWM_N0 = 6,
   parameter int PWM_N1 = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  tp8_ctl_t      ctl,
   input  logic [CW-1:0] cmp0,
   input  logic [CW-1:0] cmp1,
   input  logic [3:0]    tick,
   output logic          irq0,
   output logic          irq1,
   output logic          ev_inv,
   output logic          ev_set,
   output logic          ev_clr,
   output logic          load
);
   localparam logic [CW-1:0] MASK0 = {CW{1'b1}} >> (CW - PWM_N0);
   localparam logic [CW-1:0] MASK1 = {CW{1'b1}} >> (CW - PWM_N1);
   localparam logic [CW-1:0] MASKF = {CW{1'b1}};

   logic [CW-1:0] cnt0, cnt1, nmask;
   logic t0, tick1, m0, m1, m1x, hit0, hit1, hit16, ppg_b, ovf;

   always_comb begin
      case (ctl.plen)
         2'd0:    nmask = MASK0;
         2'd1:    nmask = MASK1;
         default: nmask = MASKF;
      endcase
      t0    = tick[ctl.ck0];
      m0    = (cnt0 == cmp0);
      m1    = (cnt1 == cmp1);
      m1x   = (cnt0 == cmp1);
      hit0  = ctl.run0 & t0 & m0;
      tick1 = (ctl.ck1 == 2'd0) ? hit0 : tick[ctl.ck1];
      hit1  = ctl.run1 & tick1 & m1;
      hit16 = hit0 & m1;
      ppg_b = ctl.run0 & t0 & m1x;
      ovf   = ctl.run0 & t0 & ((cnt0 & nmask) == nmask);
   end

   always_comb begin
      ev_inv = 1'b0;
      ev_set = 1'b0;
      ev_clr = 1'b0;
      load   = 1'b0;
      case (ctl.mode)
         MD_DUAL8: ev_inv = ctl.auto_en & (ctl.auto_src ? hit1 : hit0);
         MD_CAS16: ev_inv = ctl.auto_en & hit16;
         MD_PPG: begin
            ev_inv = hit0 | ppg_b;
            load   = ctl.dbuf_en & ppg_b;
         end
         default: begin
            ev_clr = ovf;
            ev_set = hit0 & ~ovf;
            load   = ctl.dbuf_en & ovf;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt0 <= '0;
         cnt1 <= '0;
         irq0 <= 1'b0;
         irq1 <= 1'b0;
      end else begin
         irq0 <= 1'b0;
         irq1 <= 1'b0;
         case (ctl.mode)
            MD_DUAL8: begin
               if (!ctl.run0)  cnt0 <= '0;
               else if (t0)    cnt0 <= m0 ? '0 : cnt0 + 1'b1;
               if (!ctl.run1)  cnt1 <= '0;
               else if (tick1) cnt1 <= m1 ? '0 : cnt1 + 1'b1;
               irq0 <= hit0;
               irq1 <= hit1;
            end
            MD_CAS16: begin
               if (!ctl.run0)  {cnt1, cnt0} <= '0;
               else if (t0)    {cnt1, cnt0} <= (m0 & m1) ? '0 : {cnt1, cnt0} + 1'b1;
               irq1 <= hit16;
            end
            MD_PPG: begin
               cnt1 <= '0;
               if (!ctl.run0)  cnt0 <= '0;
               else if (t0)    cnt0 <= m1x ? '0 : cnt0 + 1'b1;
               irq0 <= hit0;
               irq1 <= ppg_b;
            end
            default: begin
               cnt1 <= '0;
               if (!ctl.run0)  cnt0 <= '0;
               else if (t0)    cnt0 <= ovf ? '0 : cnt0 + 1'b1;
               irq0 <= hit0;
               irq1 <= ovf;
            end
         endcase
      end
   end
endmodule

// File: rtl/tp8_ff.sv
module tp8_ff
   import tp8_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_we,
   input  tp8_ffcmd_e sw_cmd,
   input  logic       ev_set,
   input  logic       ev_clr,
   input  logic       ev_inv,
   output logic       q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else if (sw_we) begin
         case (sw_cmd)
            FF_INV:  q <= ~q;
            FF_SET:  q <= 1'b1;
            FF_CLR:  q <= 1'b0;
            default: q <= q;
         endcase
      end
      else if (ev_set) q <= 1'b1;
      else if (ev_clr) q <= 1'b0;
      else if (ev_inv) q <= ~q;
   end
endmodule

// File: rtl/tmr_pair8.sv
module tmr_pair8
   import tp8_pkg::*;
#(
   parameter int CW     = 8,
   parameter int PRE_W  = 9,
   parameter int TAP1   = 2,
   parameter int TAP2   = 5,
   parameter int TAP3   = 9,
   parameter int PWM_N0 = 6,
   parameter int PWM_N1 = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [CW-1:0] wr_data,
   output logic          tmr_out,
   output logic          irq0,
   output logic          irq1
);
   if (CW < 8) begin : g_bad_cw
      $error("tmr_pair8: CW must be at least 8");
   end
   if (!(TAP1 > 0 && TAP1 < TAP2 && TAP2 < TAP3 && TAP3 == PRE_W)) begin : g_bad_tap
      $error("tmr_pair8: taps must rise strictly and the last must equal PRE_W");
   end
   if (!(PWM_N0 > 0 && PWM_N0 < PWM_N1 && PWM_N1 <= CW)) begin : g_bad_pwm
      $error("tmr_pair8: PWM lengths must rise and fit in CW");
   end

   tp8_ctl_t      ctl_w;
   tp8_ffcmd_e    ff_cmd_w;
   logic [CW-1:0] cmp0_w, cmp1_w;
   logic [3:0]    tick_w;
   logic          ff_we_w, load_w, ev_inv_w, ev_set_w, ev_clr_w;
   logic [1:0]    mode_w;
   logic          run0_w, run1_w;

   assign mode_w = ctl_w.mode;
   assign run0_w = ctl_w.run0;
   assign run1_w = ctl_w.run1;

   tp8_regs #(.CW(CW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .load(load_w), .ctl(ctl_w), .cmp0(cmp0_w),
      .cmp1(cmp1_w), .ff_we(ff_we_w), .ff_cmd(ff_cmd_w)
   );

   tp8_presc #(.PRE_W(PRE_W), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(ctl_w.run0 | ctl_w.run1), .tick(tick_w)
   );

   tp8_core #(.CW(CW), .PWM_N0(PWM_N0), .PWM_N1(PWM_N1)) u_core (
      .clk(clk), .rst_n(rst_n), .ctl(ctl_w), .cmp0(cmp0_w), .cmp1(cmp1_w),
      .tick(tick_w), .irq0(irq0), .irq1(irq1), .ev_inv(ev_inv_w),
      .ev_set(ev_set_w), .ev_clr(ev_clr_w), .load(load_w)
   );

   tp8_ff u_ff (
      .clk(clk), .rst_n(rst_n), .sw_we(ff_we_w), .sw_cmd(ff_cmd_w),
      .ev_set(ev_set_w), .ev_clr(ev_clr_w), .ev_inv(ev_inv_w), .q(tmr_out)
   );
endmodule

// File: rtl/tmr_pair8_chk.sv
module tmr_pair8_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [2:0] wr_addr,
   input logic [1:0] ff_cmd,
   input logic [1:0] mode,
   input logic       run0,
   input logic       run1,
   input logic       tmr_out,
   input logic       irq0,
   input logic       irq1
);
   logic ffwr;
   assign ffwr = wr_en && (wr_addr == 3'd2);

   p_setcmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ffwr && ff_cmd == 2'b01) |=> tmr_out);
   p_clrcmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ffwr && ff_cmd == 2'b10) |=> !tmr_out);
   p_invcmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ffwr && ff_cmd == 2'b00) |=> (tmr_out != $past(tmr_out)));
   p_stop_irq0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run0 |=> !irq0);
   p_stop_irq1_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((!run1 && mode == 2'b00) || (!run0 && mode != 2'b00)) |=> !irq1);
   p_cas_noirq0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == 2'b01) |-> !irq0);
   p_pwm_ovf_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq1 && $past(mode) == 2'b11 && !$past(ffwr)) |-> !tmr_out);
   p_ppg_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq0 && $past(mode) == 2'b10 && !$past(ffwr)) |-> (tmr_out != $past(tmr_out)));
endmodule

bind tmr_pair8 tmr_pair8_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .ff_cmd(wr_data[1:0]), .mode(mode_w), .run0(run0_w), .run1(run1_w),
   .tmr_out(tmr_out), .irq0(irq0), .irq1(irq1)
);

// File: tb/tmr_pair8_tb.sv
`timescale 1ns/1ps
module tmr_pair8_tb;
   localparam int LIM = 3000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       tmr_out, irq0, irq1;
   int         n_run = 0;
   int         n_fail = 0;

   always #2 clk = ~clk;

   tmr_pair8 u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tmr_out(tmr_out), .irq0(irq0), .irq1(irq1)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic pick(input int s);
      return (s == 0) ? irq0 : (s == 1) ? irq1 : tmr_out;
   endfunction

   // cycles between two rising edges of the picked signal, and high cycles inside
   task automatic measure(input int s, output int per, output int hi);
      logic p, c;
      int n;
      per = -1; hi = -1;
      c = pick(s); n = 0;
      do begin p = c; @(negedge clk); c = pick(s); n++; end
      while (!(!p && c) && n < LIM);
      if (!(!p && c)) return;
      n = 0; hi = 0;
      do begin hi += int'(c); p = c; @(negedge clk); c = pick(s); n++; end
      while (!(!p && c) && n < LIM);
      if (!p && c) per = n;
   endtask

   task automatic stop_all();
      wr(3'd0, 8'h00);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int per, hi, n, cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 tmr_out", int'(tmr_out), 0);
      check("R1 irq0", int'(irq0), 0);
      check("R1 irq1", int'(irq1), 0);
      cnt = 0;
      for (int i = 0; i < 50; i++) begin @(negedge clk); cnt += int'(irq0 | irq1); end
      check("R1 no irq while stopped", cnt, 0);

      // R2 dual 8-bit, clock every cycle
      wr(3'd3, 8'd5); wr(3'd0, 8'h01);
      measure(0, per, hi);
      check("R2 period cmp=5", per, 6);
      @(negedge clk);
      check("R2 one-cycle pulse", int'(irq0), 0);
      stop_all();
      wr(3'd3, 8'd17); wr(3'd0, 8'h01);
      measure(0, per, hi);
      check("R2 period cmp=17", per, 18);

      // R6 stop holds at zero, restart latency
      stop_all();
      cnt = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); cnt += int'(irq0); end
      check("R6 quiet when stopped", cnt, 0);
      wr(3'd3, 8'd3); wr(3'd0, 8'h01);
      n = 0;
      while (!irq0 && n < 100) begin @(negedge clk); n++; end
      check("R6 first match after cmp+1 ticks", n, 4);

      // R4 prescaler taps
      stop_all();
      wr(3'd1, 8'h04); wr(3'd3, 8'd2); wr(3'd0, 8'h01);
      measure(0, per, hi);
      check("R4 tap /4", per, 12);
      wr(3'd1, 8'h08);
      measure(0, per, hi); measure(0, per, hi);
      check("R4 tap /32", per, 96);
      stop_all();
      wr(3'd1, 8'h0C); wr(3'd3, 8'd1); wr(3'd0, 8'h01);
      measure(0, per, hi);
      check("R4 tap /512", per, 1024);

      // R3 cascade channel 1 on channel-0 matches
      stop_all();
      wr(3'd1, 8'h00); wr(3'd3, 8'd3); wr(3'd4, 8'd2); wr(3'd0, 8'h03);
      measure(1, per, hi);
      check("R3 irq1 period", per, 12);
      measure(0, per, hi);
      check("R3 irq0 period", per, 4);

      // R5 16-bit cascade
      stop_all();
      wr(3'd1, 8'h01); wr(3'd3, 8'd5); wr(3'd4, 8'd1); wr(3'd0, 8'h01);
      measure(1, per, hi);
      check("R5 16-bit period", per, 262);
      cnt = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); cnt += int'(irq0); end
      check("R5 irq0 silent", cnt, 0);

      // R7 software commands, no hardware events
      stop_all();
      wr(3'd2, 8'h02); check("R7 clear", int'(tmr_out), 0);
      wr(3'd2, 8'h01); check("R7 set", int'(tmr_out), 1);
      wr(3'd2, 8'h00); check("R7 invert", int'(tmr_out), 0);
      wr(3'd2, 8'h03); check("R7 hold", int'(tmr_out), 0);
      wr(3'd2, 8'h00); check("R7 invert again", int'(tmr_out), 1);
      wr(3'd2, 8'h03); check("R7 hold high", int'(tmr_out), 1);

      // R8 automatic inversion
      wr(3'd1, 8'h10); wr(3'd3, 8'd4); wr(3'd4, 8'd1);
      wr(3'd2, 8'h06); wr(3'd0, 8'h03);
      measure(2, per, hi);
      check("R8 ch0 source period", per, 10);
      check("R8 ch0 source high", hi, 5);
      wr(3'd2, 8'h0F);
      measure(2, per, hi); measure(2, per, hi);
      check("R8 ch1 source period", per, 16);
      check("R8 ch1 source high", hi, 8);

      // R9 pulse generation
      stop_all();
      wr(3'd2, 8'h02); wr(3'd1, 8'h02); wr(3'd3, 8'd3); wr(3'd4, 8'd9);
      wr(3'd0, 8'h01);
      measure(2, per, hi);
      check("R9 period", per, 10);
      check("R9 high", hi, 6);
      measure(0, per, hi);
      check("R9 irq0 period", per, 10);
      measure(1, per, hi);
      check("R9 irq1 period", per, 10);

      // R11 buffer in pulse generation
      wr(3'd0, 8'h05); wr(3'd3, 8'd5);
      repeat (30) @(negedge clk);
      measure(2, per, hi);
      check("R11 ppg buffered high", hi, 4);
      check("R11 ppg period", per, 10);

      // R10 PWM
      stop_all();
      wr(3'd1, 8'h03); wr(3'd3, 8'd10); wr(3'd0, 8'h01);
      measure(2, per, hi);
      check("R10 n=6 period", per, 64);
      check("R10 n=6 high", hi, 53);
      stop_all();
      wr(3'd1, 8'h43); wr(3'd3, 8'd20); wr(3'd0, 8'h01);
      measure(2, per, hi);
      check("R10 n=7 period", per, 128);
      check("R10 n=7 high", hi, 107);
      measure(1, per, hi);
      check("R10 overflow irq1 period", per, 128);

      // R11 buffer in PWM
      wr(3'd0, 8'h05); wr(3'd3, 8'd40);
      repeat (300) @(negedge clk);
      measure(2, per, hi);
      check("R11 pwm buffered high", hi, 87);

      // R11 buffer never loads in dual 8-bit mode; direct write when off
      stop_all();
      wr(3'd1, 8'h00); wr(3'd3, 8'd5); wr(3'd0, 8'h05);
      wr(3'd3, 8'd9);
      repeat (50) @(negedge clk);
      measure(0, per, hi);
      check("R11 dual8 buffered write ignored", per, 6);
      stop_all();
      wr(3'd3, 8'd9); wr(3'd0, 8'h01);
      measure(0, per, hi);
      check("R11 direct write", per, 10);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule